// File: doc/BRIEF.md
# Access-Time Running-Average Convergence Monitor

This block gathers latency statistics from a multi-requester memory arbiter. Whenever a requester's access is finally granted, the arbiter pulses that requester's bit in a completion vector. Alongside the pulse, it presents the number of cycles the access took. That number counts from the first attempt up to and including the granting cycle. The monitor keeps one grand total of cycles and one grand count of finished accesses, pooled over all requesters and all time. Any number of requesters may finish in the same cycle.

From those totals the block computes the mean access time as an unsigned fixed-point number with 8 fractional bits. It uses a sequential restoring divider and pulses a valid strobe when each result is ready. Completions keep being accepted while a division runs. The next division starts from the totals as they stand at that moment, so intermediate states may be skipped. Each new mean is compared with the previously reported mean using a divider-free cross-multiplied test. Once the relative change is below 1/5000 (0.02 percent), a sticky converged flag is raised. This lets a simulation harness know when the statistic has settled.

Top module: `access_avg_monitor`

## Requirements
- R1: While reset is asserted and right after it, `avg_o` is 0, `avg_valid_o` is 0 and `converged_o` is 0.
- R2: A lane contributes only when its bit in `done_i` is 1. Lane i's access time is `cycles_i[i*CW +: CW]`. The cycle fields of lanes whose done bit is 0 are ignored.
- R3: All lanes that complete in the same cycle are added to the total and to the count in that one cycle. With CW=16 a single lane can report up to 65535 cycles.
- R4: Each reported result equals floor(S*256/N), where S is the total of all recorded access times and N the number of completed accesses at the moment the division started. The average is taken jointly over all requesters.
- R5: `avg_valid_o` is a one-cycle pulse that accompanies each new `avg_o`. Once completions stop, the last reported result covers every completion accepted, even if several cycles of completions arrived during one division.
- R6: With (S_old, N_old) the totals behind the previously reported result and (S_new, N_new) those of the new one, the block sets `converged_o` together with the result when |S_new*N_old - S_old*N_new|*5000 < S_old*N_new. The comparison is strict; equality does not converge.
- R7: No convergence is declared for a result whose N_new is below 64, nor for the first result after reset.
- R8: Once set, `converged_o` remains 1 until reset, whatever later results are.
- R9: Completions are accepted on every cycle, including while a division is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | K | Per-requester completion strobe |
| cycles_i | input | K*CW | Packed per-requester access times, lane i at bits i*CW +: CW |
| avg_o | output | SW+FRAC | Mean access time, unsigned, FRAC fractional bits |
| avg_valid_o | output | 1 | One-cycle pulse when avg_o updates |
| converged_o | output | 1 | Sticky relative-change convergence flag |

## Verification
The bench drives garbage on idle lanes; a design that summed every lane instead of only strobed ones would report an inflated mean. It builds an exact equality case for the tolerance test (relative change of precisely 1/5000) and the next step just inside it, so a non-strict compare or a swapped product flips the flag. It feeds a constant mean across the 64-completion gate to catch an off-by-one or missing gate, and it fires completions back-to-back while the divider runs, so a design that dropped them while busy would end on a stale mean. Sticky behaviour is probed by a large jump after convergence, and a long seeded random run compares every mean and flag with a bench-side model.

// File: rtl/access_avg_monitor.sv
module access_avg_monitor #(
  parameter int K       = 4,
  parameter int CW      = 16,
  parameter int SW      = 48,
  parameter int NW      = 32,
  parameter int FRAC    = 8,
  parameter int MIN_N   = 64,
  parameter int TOL_INV = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [K-1:0]         done_i,
  input  logic [K*CW-1:0]      cycles_i,
  output logic [SW+FRAC-1:0]   avg_o,
  output logic                 avg_valid_o,
  output logic                 converged_o
);
  localparam int AW = SW + FRAC;
  localparam int PW = SW + NW;
  localparam int TW = $clog2(TOL_INV + 1);
  localparam int XW = PW + TW;
  localparam int IW = $clog2(AW + 1);

  logic [SW-1:0] batch_sum;
  logic [NW-1:0] batch_cnt;

  always_comb begin
    batch_sum = '0;
    batch_cnt = '0;
    for (int i = 0; i < K; i++) begin
      if (done_i[i]) begin
        batch_sum = batch_sum + SW'(cycles_i[i*CW +: CW]);
        batch_cnt = batch_cnt + NW'(1);
      end
    end
  end

  logic [SW-1:0] sum_q;
  logic [NW-1:0] cnt_q;
  logic          dirty_q;
  logic          busy_q;
  logic          fin_q;
  logic          start;

  assign start = dirty_q & ~busy_q & ~fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q   <= '0;
      cnt_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      sum_q   <= sum_q + batch_sum;
      cnt_q   <= cnt_q + batch_cnt;
      dirty_q <= (dirty_q & ~start) | (|done_i);
    end
  end

  logic [SW-1:0] s_snap;
  logic [NW-1:0] n_snap;
  logic [AW-1:0] dvd_q;
  logic [AW-1:0] quo_q;
  logic [NW-1:0] rem_q;
  logic [IW-1:0] iter_q;
  logic [NW:0]   rem_sh;
  logic [NW:0]   rem_sub;
  logic          ge;

  assign rem_sh  = {rem_q, dvd_q[AW-1]};
  assign rem_sub = rem_sh - {1'b0, n_snap};
  assign ge      = rem_sh >= {1'b0, n_snap};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_snap <= '0;
      n_snap <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      iter_q <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        s_snap <= sum_q;
        n_snap <= cnt_q;
        dvd_q  <= {sum_q, {FRAC{1'b0}}};
        quo_q  <= '0;
        rem_q  <= '0;
        iter_q <= IW'(AW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? rem_sub[NW-1:0] : rem_sh[NW-1:0];
        quo_q  <= {quo_q[AW-2:0], ge};
        dvd_q  <= {dvd_q[AW-2:0], 1'b0};
        iter_q <= iter_q - IW'(1);
        if (iter_q == IW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  logic [SW-1:0] prev_s;
  logic [NW-1:0] prev_n;
  logic          have_prev;
  logic [PW-1:0] x_new;
  logic [PW-1:0] x_old;
  logic [PW-1:0] x_diff;
  logic [XW-1:0] x_lhs;
  logic          conv_hit;

  assign x_new    = PW'(s_snap) * PW'(prev_n);
  assign x_old    = PW'(prev_s) * PW'(n_snap);
  assign x_diff   = (x_new > x_old) ? (x_new - x_old) : (x_old - x_new);
  assign x_lhs    = XW'(x_diff) * XW'(TOL_INV);
  assign conv_hit = have_prev & (n_snap >= NW'(MIN_N)) & (x_lhs < XW'(x_old));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_s      <= '0;
      prev_n      <= '0;
      have_prev   <= 1'b0;
      avg_o       <= '0;
      avg_valid_o <= 1'b0;
      converged_o <= 1'b0;
    end else begin
      avg_valid_o <= fin_q;
      if (fin_q) begin
        avg_o     <= quo_q;
        prev_s    <= s_snap;
        prev_n    <= n_snap;
        have_prev <= 1'b1;
        if (conv_hit) converged_o <= 1'b1;
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid_o |=> !avg_valid_o);

  // R8
  conv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    converged_o |=> converged_o);

  // R6
  conv_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(converged_o) |-> avg_valid_o);

  // R7
  conv_min_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    converged_o |-> (prev_n >= NW'(MIN_N)));

  // R3
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= $past(cnt_q));

  // R9
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && iter_q != IW'(1) |=> busy_q && $stable(n_snap));
endmodule

// File: tb/access_avg_monitor_tb.sv
module access_avg_monitor_tb;
  localparam int K = 4;
  localparam int CW = 16;
  localparam int AW = 56;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [K-1:0]      done_i = '0;
  logic [K*CW-1:0]   cycles_i = '0;
  logic [AW-1:0]     avg_o;
  logic              avg_valid_o;
  logic              converged_o;

  int checks = 0;
  int fails = 0;

  logic [127:0] ms, mn, ps, pn;
  logic         hp, mconv;

  always #4 clk = ~clk;

  access_avg_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .cycles_i(cycles_i),
    .avg_o(avg_o), .avg_valid_o(avg_valid_o), .converged_o(converged_o)
  );

  function automatic logic [127:0] exp_avg(logic [127:0] s, logic [127:0] n);
    return (s << 8) / n;
  endfunction

  function automatic logic exp_conv(logic [127:0] s, logic [127:0] n,
                                    logic [127:0] s0, logic [127:0] n0, logic h);
    logic [127:0] a, b, d;
    if (!h || n < 64) return 1'b0;
    a = s * n0;
    b = s0 * n;
    d = (a > b) ? a - b : b - a;
    return (d * 5000) < b;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    done_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ms = 0; mn = 0; ps = 0; pn = 0; hp = 0; mconv = 0;
  endtask

  task automatic drive(logic [K-1:0] d, logic [K*CW-1:0] c);
    done_i = d;
    cycles_i = c;
    for (int i = 0; i < K; i++)
      if (d[i]) begin
        ms = ms + c[i*CW +: CW];
        mn = mn + 1;
      end
    @(negedge clk);
    done_i = '0;
    cycles_i = {$urandom, $urandom};
  endtask

  task automatic wait_valid(output logic got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (avg_valid_o) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic batch(string req, logic [K-1:0] d, logic [K*CW-1:0] c);
    logic got;
    drive(d, c);
    wait_valid(got);
    chk({req, " result strobe"}, got, 1'b1);
    chk({req, " average"}, avg_o, exp_avg(ms, mn));
    mconv = mconv | exp_conv(ms, mn, ps, pn, hp);
    chk({req, " converged"}, converged_o, mconv);
    ps = ms; pn = mn; hp = 1'b1;
  endtask

  function automatic logic [K*CW-1:0] all4(int v);
    return {CW'(v), CW'(v), CW'(v), CW'(v)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic got;
    logic [K-1:0] rd;
    logic [K*CW-1:0] rc;
    void'($urandom(32'd1234));
    ms = 0; mn = 0; ps = 0; pn = 0; hp = 0; mconv = 0;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 avg in reset", avg_o, 0);
    chk("R1 valid in reset", avg_valid_o, 0);
    chk("R1 conv in reset", converged_o, 0);
    do_reset();
    @(negedge clk);
    chk("R1 avg after reset", avg_o, 0);
    chk("R1 valid after reset", avg_valid_o, 0);
    chk("R1 conv after reset", converged_o, 0);

    // R4 single lane, access time 1 -> 1.0 = 256
    batch("R4 single", 4'b0001, {16'd0, 16'd0, 16'd0, 16'd1});
    chk("R4 one cycle mean", avg_o, 256);
    // R3 all lanes together
    batch("R3 multi", 4'b1111, {16'd5, 16'd3, 16'd2, 16'd1});
    chk("R3 pooled mean", avg_o, (12 << 8) / 5);
    // R2 idle lanes carry garbage
    batch("R2 idle lanes", 4'b0101, {16'hFFFF, 16'd7, 16'hABCD, 16'd4});
    chk("R2 masked mean", avg_o, (23 << 8) / 7);
    // R3 maximum field value
    batch("R3 max field", 4'b1000, {16'hFFFF, 16'd0, 16'd0, 16'd0});

    // R7 constant mean across the 64 gate
    do_reset();
    for (int b = 1; b <= 16; b++) begin
      batch("R7 gate", 4'b1111, all4(2));
      if (b == 15) chk("R7 below 64 not converged", converged_o, 0);
      if (b == 16) chk("R6 constant mean converges at 64", converged_o, 1);
    end
    // R8 large jump keeps flag
    batch("R8 jump", 4'b1111, all4(60000));
    chk("R8 sticky", converged_o, 1);
    do_reset();
    chk("R1 reset clears flag", converged_o, 0);

    // R9/R5 back-to-back completions during division, then R6 boundary
    for (int b = 0; b < 14; b++) drive(4'b1111, all4(1000));
    drive(4'b1111, all4(500));
    for (int i = 0; i < 300; i++) @(negedge clk);
    chk("R9 final mean after burst", avg_o, (128'd58000 << 8) / 60);
    chk("R5 burst converged", converged_o, 0);
    ps = ms; pn = mn; hp = 1'b1;
    batch("R6 lift to 64", 4'b1111, all4(1500));
    chk("R6 64 not converged", converged_o, 0);
    batch("R6 boundary", 4'b0010, {16'd0, 16'd0, 16'd1013, 16'd0});
    chk("R6 exact 1/5000 not converged", converged_o, 0);
    batch("R6 inside", 4'b0100, {16'd0, 16'd1000, 16'd0, 16'd0});
    chk("R6 inside tolerance converged", converged_o, 1);

    // random run
    do_reset();
    for (int b = 0; b < 220; b++) begin
      rd = K'($urandom_range(1, 15));
      rc = '0;
      for (int i = 0; i < K; i++) rc[i*CW +: CW] = CW'($urandom_range(1, 12));
      if (b % 7 == 0) rc = rc | {CW'($urandom_range(0, 999)), 48'd0};
      batch("R4 R6 random", rd, rc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule